// File: doc/BRIEF.md
# Configuration Access Port for a PCI Host Bridge

This block gives a host processor its path into PCI configuration space. Software first writes a 32-bit configuration address into a latch at byte offset 0x0. It then reads or writes the data window at offsets 0x4 to 0x7, and the block turns that access into one request toward the configuration-cycle engine. The request address is the latched address with the window's low two offset bits merged in by OR. The request is issued whether or not bit 31 of the latched address is set. The block waits for the bus side's acknowledge before it finishes the host access, and it returns read data right-aligned to the host.

Register data is little-endian. A byte, halfword or word access on the data window becomes byte enables and a lane shift on the way out, and a matching shift and mask on the way back. A second, local region starts at a parameterised base (0x80000 by default). Its first 64 bytes are the bridge's own configuration header and are read and written in place, with no bus request. The rest of that region, and every other unmapped offset, reads as zero and drops writes. The device number of the latched address is also driven out, so interrupt routing can pick the slot.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the address latch reads 0, every header word reads 0, `cfg_req` and `hst_done` are low, and `cfg_slot` is 0.
- R2: An access to offsets 0x0 to 0x3 reads or writes the whole 32-bit address latch, whatever the size. `hst_done` rises exactly one cycle after the access is accepted, and a read returns the last value written.
- R3: An access to offsets 0x4 to 0x7 raises `cfg_req`. `cfg_addr` equals the latched address ORed with host address bits [1:0], and `cfg_we` follows the access direction.
- R4: The data-window request is issued whether bit 31 of the latched address is 0 or 1.
- R5: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. With `off` = host address bits [1:0], `cfg_be` is 1<<off for a byte, 4'b0011<<(2*off[1]) for a halfword, and 4'b1111 for a word.
- R6: On a data-window write, the size-masked low bits of `hst_wdata` appear on `cfg_wdata` shifted up to byte lane `base`. `base` is off, 2*off[1] or 0 for byte, halfword and word. All other lanes are zero, and `cfg_wdata` is zero on reads.
- R7: On a data-window read, `hst_rdata` is `cfg_rdata` shifted down by 8*base and masked to the access size. A data-window write returns 0 on `hst_rdata`.
- R8: `cfg_req`, `cfg_addr`, `cfg_be`, `cfg_we` and `cfg_wdata` hold steady until `cfg_ack`. `cfg_req` drops in the cycle after `cfg_ack`, and `hst_done` pulses for one cycle in that same cycle. With an acknowledge d cycles late, the access takes 2+d cycles.
- R9: Offsets from the local base up to base+0x3F read and write a 16-word header store. Writes use the byte enables and lane placement of R5 and R6, reads use the alignment of R7, every access completes in one cycle, and no bus request is made.
- R10: Any other offset, including base+0x40 to base+0xFE, reads 0, ignores writes, completes in one cycle and makes no bus request.
- R11: `cfg_slot` equals bits [15:11] of the latched address, which is the device/function number shifted right by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access request, held until `hst_done` |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Host byte offset |
| hst_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| hst_wdata | input | 32 | Right-aligned write data |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Right-aligned read data, valid with `hst_done` |
| cfg_req | output | 1 | Configuration request to the bus side |
| cfg_we | output | 1 | Request direction |
| cfg_addr | output | 32 | Latched address ORed with offset bits |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Bus-side acknowledge |
| cfg_rdata | input | 32 | Bus-side read data, lane-placed |
| cfg_slot | output | 5 | Interrupt slot of the latched device |

## Verification
Data-window traffic mixes random sizes, offsets, directions and acknowledge delays of 0 to 3 cycles. These runs separate a wrong OR of the offset, a wrong lane shift or mask, a wrong byte-enable pattern and an off-by-one in completion latency. Latched addresses are tried with bit 31 set and with it clear, which shows whether a request is wrongly gated by that bit. Header traffic uses byte and halfword writes over full words, checked against a bench model, to expose lane-merge errors. Accesses to the gap above the header and to unmapped offsets confirm that nothing is stored and that no request leaks to the bus.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } cfg_state_e;

    typedef enum logic [1:0] {
        K_LATCH = 2'd0,
        K_WIN   = 2'd1,
        K_HDR   = 2'd2,
        K_NONE  = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        cfg_state_e  st;
        logic [31:0] areg;
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [1:0]  size;
        logic [1:0]  off;
        logic        done;
        logic [31:0] rdata;
    } cfg_ctl_s;

endpackage

// File: rtl/cfg_lane_map.sv
module cfg_lane_map (
    input  logic [1:0]  size_i,
    input  logic [1:0]  off_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] rdata_lane_i,
    output logic [3:0]  be_o,
    output logic [31:0] wdata_lane_o,
    output logic [31:0] rdata_right_o
);
    logic [1:0]  base;
    logic [31:0] mask;

    always_comb begin
        case (size_i)
            2'd0: begin
                base = off_i;
                mask = 32'h0000_00FF;
                be_o = 4'b0001 << off_i;
            end
            2'd1: begin
                base = {off_i[1], 1'b0};
                mask = 32'h0000_FFFF;
                be_o = 4'b0011 << {off_i[1], 1'b0};
            end
            default: begin
                base = 2'd0;
                mask = 32'hFFFF_FFFF;
                be_o = 4'b1111;
            end
        endcase
        wdata_lane_o  = (wdata_i & mask) << {base, 3'b000};
        rdata_right_o = (rdata_lane_i >> {base, 3'b000}) & mask;
    end
endmodule

// File: rtl/cfg_hdr_store.sv
module cfg_hdr_store #(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [3:0]       be_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rd_word_o
);
    typedef struct packed {
        logic [WORDS-1:0][31:0] mem;
    } hdr_s;

    hdr_s hdr_d, hdr_q;

    always_comb begin
        hdr_d = hdr_q;
        if (wr_en_i) begin
            for (int b = 0; b < 4; b++) begin
                if (be_i[b]) begin
                    hdr_d.mem[idx_i][8*b +: 8] = wdata_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    assign rd_word_o = hdr_q.mem[idx_i];

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(hdr_q));
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
    import cfg_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic        we_i,
    input  cfg_kind_e   kind_i,
    input  logic [1:0]  size_i,
    input  logic [1:0]  off_i,
    input  logic [31:0] wdata_i,
    input  logic [3:0]  be_i,
    input  logic [31:0] wlane_i,
    input  logic [31:0] hdr_right_i,
    input  logic        ack_i,
    input  logic [31:0] bus_right_i,
    output logic        idle_o,
    output logic [1:0]  held_size_o,
    output logic [1:0]  held_off_o,
    output logic [31:0] areg_o,
    output logic        done_o,
    output logic [31:0] rdata_o,
    output logic        req_o,
    output logic        req_we_o,
    output logic [31:0] req_addr_o,
    output logic [3:0]  req_be_o,
    output logic [31:0] req_wdata_o
);
    cfg_ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (valid_i) begin
                    ctl_d.st    = ST_DONE;
                    ctl_d.done  = 1'b1;
                    ctl_d.rdata = '0;
                    case (kind_i)
                        K_LATCH: begin
                            if (we_i) ctl_d.areg  = wdata_i;
                            else      ctl_d.rdata = ctl_q.areg;
                        end
                        K_HDR: begin
                            if (!we_i) ctl_d.rdata = hdr_right_i;
                        end
                        K_WIN: begin
                            ctl_d.st    = ST_BUS;
                            ctl_d.done  = 1'b0;
                            ctl_d.req   = 1'b1;
                            ctl_d.we    = we_i;
                            ctl_d.addr  = ctl_q.areg | {30'd0, off_i};
                            ctl_d.be    = be_i;
                            ctl_d.wdata = we_i ? wlane_i : 32'd0;
                            ctl_d.size  = size_i;
                            ctl_d.off   = off_i;
                        end
                        default: ;
                    endcase
                end
            end
            ST_BUS: begin
                if (ack_i) begin
                    ctl_d.req   = 1'b0;
                    ctl_d.st    = ST_DONE;
                    ctl_d.done  = 1'b1;
                    ctl_d.rdata = ctl_q.we ? 32'd0 : bus_right_i;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign idle_o      = (ctl_q.st == ST_IDLE);
    assign held_size_o = ctl_q.size;
    assign held_off_o  = ctl_q.off;
    assign areg_o      = ctl_q.areg;
    assign done_o      = ctl_q.done;
    assign rdata_o     = ctl_q.rdata;
    assign req_o       = ctl_q.req;
    assign req_we_o    = ctl_q.we;
    assign req_addr_o  = ctl_q.addr;
    assign req_be_o    = ctl_q.be;
    assign req_wdata_o = ctl_q.wdata;

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_be_o)
                            && $stable(req_wdata_o) && $stable(req_we_o));

    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i |=> !req_o && done_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_be_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_be_o == 4'b1111 || req_be_o == 4'b0011 || req_be_o == 4'b1100
                   || $countones(req_be_o) == 1));

    p_addr_join_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_addr_o[31:2] == areg_o[31:2]));

    p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !req_o);
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] REG_BASE  = 20'h80000,
    parameter int                HDR_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [1:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic              hst_done,
    output logic [31:0]       hst_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [31:0]       cfg_addr,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata,
    output logic [4:0]        cfg_slot
);
    localparam int                HDR_WORDS = HDR_BYTES / 4;
    localparam int                IDX_W     = $clog2(HDR_WORDS);
    localparam logic [ADDR_W:0]   HDR_LO    = {1'b0, REG_BASE};
    localparam logic [ADDR_W:0]   HDR_HI    = HDR_LO + (ADDR_W+1)'(HDR_BYTES);

    cfg_kind_e   kind;
    logic [1:0]  off;
    logic [3:0]  be_now;
    logic [31:0] wlane_now, hdr_word, hdr_right, bus_right, areg, unused_wl;
    logic [3:0]  unused_be;
    logic [1:0]  held_size, held_off;
    logic        idle;
    logic [ADDR_W:0] addr_ext;

    assign off      = hst_addr[1:0];
    assign addr_ext = {1'b0, hst_addr};

    always_comb begin
        if (hst_addr[ADDR_W-1:2] == '0)
            kind = K_LATCH;
        else if (hst_addr[ADDR_W-1:2] == (ADDR_W-2)'(1))
            kind = K_WIN;
        else if (addr_ext >= HDR_LO && addr_ext < HDR_HI)
            kind = K_HDR;
        else
            kind = K_NONE;
    end

    cfg_lane_map u_host_lanes (
        .size_i       (hst_size),
        .off_i        (off),
        .wdata_i      (hst_wdata),
        .rdata_lane_i (hdr_word),
        .be_o         (be_now),
        .wdata_lane_o (wlane_now),
        .rdata_right_o(hdr_right)
    );

    cfg_lane_map u_bus_lanes (
        .size_i       (held_size),
        .off_i        (held_off),
        .wdata_i      (32'd0),
        .rdata_lane_i (cfg_rdata),
        .be_o         (unused_be),
        .wdata_lane_o (unused_wl),
        .rdata_right_o(bus_right)
    );

    cfg_hdr_store #(.WORDS(HDR_WORDS)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (idle && hst_valid && hst_we && kind == K_HDR),
        .idx_i    (hst_addr[IDX_W+1:2]),
        .be_i     (be_now),
        .wdata_i  (wlane_now),
        .rd_word_o(hdr_word)
    );

    cfg_txn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (hst_valid),
        .we_i       (hst_we),
        .kind_i     (kind),
        .size_i     (hst_size),
        .off_i      (off),
        .wdata_i    (hst_wdata),
        .be_i       (be_now),
        .wlane_i    (wlane_now),
        .hdr_right_i(hdr_right),
        .ack_i      (cfg_ack),
        .bus_right_i(bus_right),
        .idle_o     (idle),
        .held_size_o(held_size),
        .held_off_o (held_off),
        .areg_o     (areg),
        .done_o     (hst_done),
        .rdata_o    (hst_rdata),
        .req_o      (cfg_req),
        .req_we_o   (cfg_we),
        .req_addr_o (cfg_addr),
        .req_be_o   (cfg_be),
        .req_wdata_o(cfg_wdata)
    );

    assign cfg_slot = areg[15:11];

    p_local_no_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle && hst_valid && kind != K_WIN |=> !cfg_req && hst_done);

    p_latch_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle && hst_valid && kind == K_LATCH |=> hst_done);
endmodule

// File: tb/cfg_access_port_test.sv
`timescale 1ns/1ps
module cfg_access_port_test;
    localparam int ADDR_W = 20;
    localparam logic [19:0] BASE = 20'h80000;

    logic        clk = 0, rst_n = 0;
    logic        hst_valid = 0, hst_we = 0;
    logic [19:0] hst_addr = '0;
    logic [1:0]  hst_size = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_done;
    logic [31:0] hst_rdata;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0]  cfg_be;
    logic        cfg_ack = 0;
    logic [31:0] cfg_rdata = '0;
    logic [4:0]  cfg_slot;

    int total = 0, bad = 0;

    cfg_access_port uut (.*);

    always #4 clk = ~clk;

    // bus-side responder
    int dly_cfg = 0, dly_left = 0, req_count = 0, stab_bad = 0;
    bit in_req = 0;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0]  cap_be;
    logic        cap_we;

    function automatic logic [31:0] bus_fn(logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[31:24], a[15:8] + 8'd1, a[23:16]};
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cfg_ack = 0; in_req = 0;
        end else if (cfg_req && !cfg_ack) begin
            if (!in_req) begin
                in_req = 1; cap_addr = cfg_addr; cap_be = cfg_be;
                cap_wdata = cfg_wdata; cap_we = cfg_we; dly_left = dly_cfg;
            end else if (cfg_addr !== cap_addr || cfg_be !== cap_be ||
                         cfg_wdata !== cap_wdata || cfg_we !== cap_we) begin
                stab_bad++;
            end
            if (dly_left == 0) begin
                cfg_ack = 1; cfg_rdata = bus_fn(cfg_addr); req_count++;
            end else dly_left--;
        end else begin
            cfg_ack = 0; in_req = 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] e_base(logic [1:0] sz, logic [1:0] o);
        if (sz == 0) return o;
        if (sz == 1) return {o[1], 1'b0};
        return 2'd0;
    endfunction
    function automatic logic [3:0] e_be(logic [1:0] sz, logic [1:0] o);
        if (sz == 0) return 4'b0001 << o;
        if (sz == 1) return 4'b0011 << {o[1], 1'b0};
        return 4'b1111;
    endfunction
    function automatic logic [31:0] e_mask(logic [1:0] sz);
        if (sz == 0) return 32'hFF;
        if (sz == 1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    logic [31:0] rd;
    int lat;

    task automatic acc(input logic we, input logic [19:0] a, input logic [1:0] sz,
                       input logic [31:0] wd);
        @(negedge clk);
        hst_valid = 1; hst_we = we; hst_addr = a; hst_size = sz; hst_wdata = wd;
        lat = 0;
        do begin
            @(posedge clk); #1; lat++;
        end while (!hst_done && lat < 50);
        rd = hst_rdata;
        @(negedge clk);
        hst_valid = 0;
    endtask

    logic [31:0] areg_m = 0;
    logic [31:0] hdr_m [16];

    task automatic win(input logic we, input logic [1:0] o, input logic [1:0] sz,
                       input logic [31:0] wd, input int d);
        int rc0;
        logic [31:0] ea;
        logic [1:0]  b;
        dly_cfg = d; rc0 = req_count;
        ea = areg_m | {30'd0, o};
        b = e_base(sz, o);
        acc(we, 20'h4 | {18'd0, o}, sz, wd);
        chk("R3 one request", req_count - rc0, 1);
        chk("R3 address", cap_addr, ea);
        chk("R3 direction", {31'd0, cap_we}, {31'd0, we});
        chk("R5 byte enables", {28'd0, cap_be}, {28'd0, e_be(sz, o)});
        chk("R6 write lanes", cap_wdata, we ? ((wd & e_mask(sz)) << (8*b)) : 32'd0);
        chk("R7 read data", rd, we ? 32'd0 : ((bus_fn(ea) >> (8*b)) & e_mask(sz)));
        chk("R8 latency", lat, 2 + d);
        chk("R8 request dropped", {31'd0, cfg_req}, 0);
    endtask

    task automatic hdr(input logic we, input logic [5:0] o, input logic [1:0] sz,
                       input logic [31:0] wd);
        int rc0;
        logic [1:0]  b;
        logic [3:0]  be;
        logic [31:0] wl;
        rc0 = req_count;
        b = e_base(sz, o[1:0]); be = e_be(sz, o[1:0]);
        acc(we, BASE + {14'd0, o}, sz, wd);
        chk("R9 one-cycle, no request", lat + 10 * (req_count - rc0), 1);
        if (we) begin
            wl = (wd & e_mask(sz)) << (8*b);
            for (int k = 0; k < 4; k++)
                if (be[k]) hdr_m[o[5:2]][8*k +: 8] = wl[8*k +: 8];
        end else begin
            chk("R9 header read", rd, (hdr_m[o[5:2]] >> (8*b)) & e_mask(sz));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) hdr_m[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 req low in reset", {31'd0, cfg_req}, 0);
        chk("R1 done low in reset", {31'd0, hst_done}, 0);
        @(negedge clk); rst_n = 1;
        chk("R1 slot", {27'd0, cfg_slot}, 0);
        acc(0, 20'h0, 2'd2, 0);
        chk("R1 latch reset value", rd, 0);
        acc(0, BASE + 20'h3C, 2'd2, 0);
        chk("R1 header reset value", rd, 0);

        // R2 latch write / readback / latency
        acc(1, 20'h2, 2'd0, 32'h8000_1A04);
        chk("R2 write latency", lat, 1);
        areg_m = 32'h8000_1A04;
        acc(0, 20'h0, 2'd2, 0);
        chk("R2 readback", rd, areg_m);
        chk("R2 read latency", lat, 1);
        chk("R11 slot", {27'd0, cfg_slot}, {27'd0, areg_m[15:11]});

        // R4 enable bit set and clear
        win(0, 2'd0, 2'd2, 0, 0);
        acc(1, 20'h0, 2'd2, 32'h0000_2208);
        areg_m = 32'h0000_2208;
        win(0, 2'd3, 2'd0, 0, 1);
        chk("R4 request with bit31 clear", cap_addr, 32'h0000_220B);
        chk("R11 slot after rewrite", {27'd0, cfg_slot}, 5'd4);
        win(1, 2'd1, 2'd1, 32'hDEAD_BEEF, 3);

        // R9 header directed
        hdr(1, 6'h08, 2'd2, 32'h1122_3344);
        hdr(1, 6'h0D, 2'd0, 32'h0000_00AB);
        hdr(1, 6'h0A, 2'd1, 32'hFFFF_C0DE);
        hdr(0, 6'h08, 2'd2, 0);
        hdr(0, 6'h0C, 2'd2, 0);
        hdr(0, 6'h0B, 2'd0, 0);

        // R10 gap and unmapped
        begin
            int rc0;
            rc0 = req_count;
            acc(1, BASE + 20'h40, 2'd2, 32'hCAFE_F00D);
            chk("R10 write latency", lat, 1);
            acc(0, BASE + 20'h40, 2'd2, 0);
            chk("R10 gap reads zero", rd, 0);
            acc(1, 20'h12344, 2'd2, 32'h5555_AAAA);
            acc(0, 20'h12344, 2'd2, 0);
            chk("R10 unmapped reads zero", rd, 0);
            chk("R10 no bus request", req_count - rc0, 0);
            acc(0, 20'h0, 2'd2, 0);
            chk("R10 latch untouched", rd, areg_m);
        end

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            if (op == 0) begin
                areg_m = $urandom;
                acc(1, {18'd0, 2'($urandom)}, 2'($urandom), areg_m);
                chk("R2 random latch latency", lat, 1);
                chk("R11 random slot", {27'd0, cfg_slot}, {27'd0, areg_m[15:11]});
            end else if (op == 3) begin
                hdr(1'($urandom), 6'($urandom), 2'($urandom), $urandom);
            end else begin
                win(1'($urandom), 2'($urandom), 2'($urandom), $urandom, $urandom % 4);
            end
        end
        chk("R8 attributes stable while waiting", stab_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule